// File: doc/BRIEF.md
# Loopback Packet Client Statistics Registers

This block is the register face of a loopback packet client. Software starts and stops a simple packet generator through a control word. Six event counters track start-of-packet, end-of-packet and error strobes on the transmit and receive streams. A run of the generator ends by itself once a fixed number of transmit packets have completed. Comparing the transmit and receive counts after a run shows whether every frame made the round trip.

Each counter is wider than the 32-bit register port, so software reads it as a lower word and an upper word. Setting a snapshot bit in the control word copies all six counters into shadow registers in the same clock cycle. While that bit stays set, reads return the frozen copies, so the two halves of one counter and the counts of different counters all belong to one instant. The live counters keep counting underneath. A stop command halts the generator and clears the live counters.

Top module: `pktgen_stats_regs`

## Requirements
- R1: After reset, gen_enable is low, the control word reads 0 and every counter word reads 0.
- R2: A write to offset 0x00 with bit 0 set, unless bits [2:0] equal 3'b100, raises gen_enable from the next clock. It also restarts the packet count of the run, even when a run is already in progress.
- R3: While gen_enable is high, each clock with the transmit end-of-packet strobe high counts one packet. gen_enable drops on the clock that counts the BURST_PKTS-th packet (default 16).
- R4: A write to offset 0x00 with bits [2:0] equal to 3'b100 lowers gen_enable and sets all six live counters to zero. The clear wins over an event strobe in the same cycle.
- R5: Each event strobe that is high at a clock edge adds one to its counter. In tx_evt and rx_evt, bit 0 is start-of-packet, bit 1 is end-of-packet and bit 2 is error.
- R6: Counter map: transmit start, end and error sit at 0x20, 0x28 and 0x30, and receive start, end and error at 0x38, 0x40 and 0x48. Bits [31:0] are read at the base offset and bits [63:32] at base+4.
- R7: Reading offset 0x00 returns gen_enable in bit 0 and the snapshot bit in bit 6. All other bits read 0. Every write to 0x00 sets the snapshot bit to wdata bit 6.
- R8: When the snapshot bit goes from 0 to 1, all six live counters are copied into the shadow registers at once. Writing 1 again while it is already 1 does not reload them.
- R9: While the snapshot bit is 1, counter reads return the shadow values and the live counters keep counting. Once the bit is cleared, reads return the live values again.
- R10: Reads of offsets other than 0x00 and the twelve counter words, including unaligned offsets, return 0. Writes to any offset other than 0x00 change no counter and no control state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_wr | input | 1 | Write strobe, one write per clock |
| reg_addr | input | ADDR_W | Byte offset of the register access |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr, combinational |
| tx_evt | input | 3 | Transmit strobes {err, eop, sop} |
| rx_evt | input | 3 | Receive strobes {err, eop, sop} |
| gen_enable | output | 1 | Packet generator run enable |

## Verification
The bench first runs a full burst with transmit and receive start/end strobes paired, which shows whether the burst length and the per-stream counters are right. Strobes on a single stream, and all three strobes at once, separate the six counters and show whether the lower and upper word map is correct. A snapshot taken before further events, then re-armed and then dropped, separates shadow reads from live reads and a first capture from a repeated one. A stop that coincides with strobes, and a second start during a run, test the clear priority and the restart of the burst count.

// File: rtl/pgs_pkg.sv
package pgs_pkg;
   localparam int REG_W      = 32;
   localparam int NUM_CNT    = 6;
   localparam int OFS_CTRL   = 'h00;
   localparam int CNT_BASE   = 'h20;
   localparam int CNT_STRIDE = 8;
   localparam int CNT_END    = CNT_BASE + NUM_CNT * CNT_STRIDE;
   localparam int CTL_START  = 0;
   localparam int CTL_SNAP   = 6;
   localparam logic [2:0] STOP_CODE = 3'b100;

   typedef enum int {
      EV_SOP = 0,
      EV_EOP = 1,
      EV_ERR = 2
   } evt_bit_e;
endpackage

// File: rtl/pgs_ctrl.sv
module pgs_ctrl
   import pgs_pkg::*;
#(
   parameter int BURST_PKTS = 16,
   parameter int ADDR_W     = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] addr,
   input  logic [REG_W-1:0]  wdata,
   input  logic              tx_eop,
   output logic              gen_en,
   output logic              snap_on,
   output logic              snap_load,
   output logic              clr_cnt
);
   localparam int BW = (BURST_PKTS < 2) ? 1 : $clog2(BURST_PKTS);
   localparam logic [BW-1:0] LAST = BW'(BURST_PKTS - 1);

   logic          ctrl_hit, cmd_stop, cmd_start, snap_nxt;
   logic [BW-1:0] burst_q;
   logic          run_q, snap_q;

   assign ctrl_hit  = wr_en && (addr == ADDR_W'(OFS_CTRL));
   assign cmd_stop  = ctrl_hit && (wdata[2:0] == STOP_CODE);
   assign cmd_start = ctrl_hit && !cmd_stop && wdata[CTL_START];
   assign snap_nxt  = ctrl_hit ? wdata[CTL_SNAP] : snap_q;
   assign snap_load = snap_nxt && !snap_q;
   assign clr_cnt   = cmd_stop;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_q   <= 1'b0;
         burst_q <= '0;
      end else if (cmd_stop) begin
         run_q   <= 1'b0;
         burst_q <= '0;
      end else if (cmd_start) begin
         run_q   <= 1'b1;
         burst_q <= '0;
      end else if (run_q && tx_eop) begin
         if (burst_q == LAST) begin
            run_q   <= 1'b0;
            burst_q <= '0;
         end else begin
            burst_q <= burst_q + 1'b1;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) snap_q <= 1'b0;
      else        snap_q <= snap_nxt;
   end

   assign gen_en  = run_q;
   assign snap_on = snap_q;

   // R4
   stop_halts_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_stop |=> !gen_en);
   // R2
   start_runs_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_start |=> gen_en);
   // R3
   burst_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      gen_en |-> (int'(burst_q) < BURST_PKTS));
   // R3
   run_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(gen_en) |-> $past(cmd_start));
endmodule

// File: rtl/pgs_stat_cnt.sv
module pgs_stat_cnt #(
   parameter int CNT_W = 64
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             inc,
   input  logic             cap,
   output logic [CNT_W-1:0] live,
   output logic [CNT_W-1:0] shadow
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   live <= '0;
      else if (clr) live <= '0;
      else if (inc) live <= live + 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   shadow <= '0;
      else if (cap) shadow <= live;
   end

   // R4
   clear_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (live == '0));
   // R5
   step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (inc && !clr) |=> (live == $past(live) + CNT_W'(1)));
   // R8
   capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cap |=> (shadow == $past(live)));
   // R8
   shadow_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !cap |=> $stable(shadow));
endmodule

// File: rtl/pgs_rd_mux.sv
module pgs_rd_mux
   import pgs_pkg::*;
#(
   parameter int ADDR_W = 8,
   parameter int CNT_W  = 64
) (
   input  logic                            clk,
   input  logic                            rst_n,
   input  logic [ADDR_W-1:0]               addr,
   input  logic [REG_W-1:0]                ctrl_word,
   input  logic [NUM_CNT-1:0][CNT_W-1:0]   cnt_view,
   output logic [REG_W-1:0]                rdata
);
   logic [NUM_CNT-1:0][REG_W-1:0] lo_w, hi_w;
   logic [ADDR_W-1:0]             off;
   logic                          in_win;

   for (genvar k = 0; k < NUM_CNT; k++) begin : g_split
      if (CNT_W > REG_W) begin : g_wide
         assign lo_w[k] = cnt_view[k][REG_W-1:0];
         assign hi_w[k] = REG_W'(cnt_view[k] >> REG_W);
      end else begin : g_narrow
         assign lo_w[k] = REG_W'(cnt_view[k]);
         assign hi_w[k] = '0;
      end
   end

   assign off    = addr - ADDR_W'(CNT_BASE);
   assign in_win = (addr >= ADDR_W'(CNT_BASE)) && (addr < ADDR_W'(CNT_END))
                   && (off[1:0] == 2'b00);

   always_comb begin
      rdata = '0;
      if (addr == ADDR_W'(OFS_CTRL)) rdata = ctrl_word;
      for (int k = 0; k < NUM_CNT; k++) begin
         if (in_win && (off[ADDR_W-1:3] == (ADDR_W-3)'(k)))
            rdata = off[2] ? hi_w[k] : lo_w[k];
      end
   end

   // R10
   unmapped_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (addr > ADDR_W'(CNT_END)) |-> (rdata == '0));
endmodule

// File: rtl/pktgen_stats_regs.sv
module pktgen_stats_regs
   import pgs_pkg::*;
#(
   parameter int CNT_W      = 64,
   parameter int BURST_PKTS = 16,
   parameter int ADDR_W     = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic [31:0]       reg_wdata,
   output logic [31:0]       reg_rdata,
   input  logic [2:0]        tx_evt,
   input  logic [2:0]        rx_evt,
   output logic              gen_enable
);
   initial begin
      assert (CNT_W >= 1 && CNT_W <= 2 * REG_W)
         else $fatal(1, "CNT_W out of range");
      assert (BURST_PKTS >= 1)
         else $fatal(1, "BURST_PKTS must be positive");
      assert (ADDR_W >= 4 && ADDR_W <= 31 && (1 << ADDR_W) > CNT_END)
         else $fatal(1, "ADDR_W too small for the counter map");
   end

   logic                          snap_on, snap_load, clr_cnt;
   logic [2*3-1:0]                ev_all;
   logic [NUM_CNT-1:0][CNT_W-1:0] live_v, shad_v, view_v;
   logic [REG_W-1:0]              ctrl_word;

   assign ev_all = {rx_evt, tx_evt};

   pgs_ctrl #(.BURST_PKTS(BURST_PKTS), .ADDR_W(ADDR_W)) u_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (reg_wr),
      .addr      (reg_addr),
      .wdata     (reg_wdata),
      .tx_eop    (tx_evt[EV_EOP]),
      .gen_en    (gen_enable),
      .snap_on   (snap_on),
      .snap_load (snap_load),
      .clr_cnt   (clr_cnt)
   );

   for (genvar k = 0; k < NUM_CNT; k++) begin : g_cnt
      pgs_stat_cnt #(.CNT_W(CNT_W)) u_cnt (
         .clk    (clk),
         .rst_n  (rst_n),
         .clr    (clr_cnt),
         .inc    (ev_all[k]),
         .cap    (snap_load),
         .live   (live_v[k]),
         .shadow (shad_v[k])
      );
   end

   assign view_v = snap_on ? shad_v : live_v;

   always_comb begin
      ctrl_word            = '0;
      ctrl_word[CTL_START] = gen_enable;
      ctrl_word[CTL_SNAP]  = snap_on;
   end

   pgs_rd_mux #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_rd (
      .clk       (clk),
      .rst_n     (rst_n),
      .addr      (reg_addr),
      .ctrl_word (ctrl_word),
      .cnt_view  (view_v),
      .rdata     (reg_rdata)
   );

   // R9
   snap_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (snap_on && reg_addr == ADDR_W'(CNT_BASE)) |-> (reg_rdata == REG_W'(shad_v[0])));
   // R10
   foreign_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && reg_addr != ADDR_W'(OFS_CTRL)) |=> $stable(snap_on));
endmodule

// File: tb/pktgen_stats_regs_tb.sv
module pktgen_stats_regs_tb;
   localparam int BURST = 16;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_wr = 1'b0;
   logic [7:0]  reg_addr = '0;
   logic [31:0] reg_wdata = '0;
   logic [2:0]  tx_evt = '0;
   logic [2:0]  rx_evt = '0;
   wire  [31:0] reg_rdata;
   wire         gen_enable;

   int    errs = 0;
   int    checks = 0;
   string phase = "R1";

   always #10 clk = ~clk;

   pktgen_stats_regs u_dut (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .tx_evt(tx_evt),
      .rx_evt(rx_evt), .gen_enable(gen_enable)
   );

   // behavioural reference model
   longint unsigned m_live[6];
   longint unsigned m_shad[6];
   bit m_run, m_snap, m_stop, m_start, m_snew;
   int m_burst;
   logic [5:0] m_ev;

   always @(posedge clk) begin
      if (!rst_n) begin
         foreach (m_live[i]) begin m_live[i] = 0; m_shad[i] = 0; end
         m_run = 0; m_snap = 0; m_burst = 0;
      end else begin
         m_stop  = reg_wr && reg_addr == 8'h00 && reg_wdata[2:0] == 3'b100;
         m_start = reg_wr && reg_addr == 8'h00 && !m_stop && reg_wdata[0];
         m_snew  = (reg_wr && reg_addr == 8'h00) ? reg_wdata[6] : m_snap;
         if (m_snew && !m_snap) foreach (m_live[i]) m_shad[i] = m_live[i];
         m_snap = m_snew;
         m_ev = {rx_evt, tx_evt};
         foreach (m_live[i]) begin
            if (m_stop) m_live[i] = 0;
            else if (m_ev[i]) m_live[i] = m_live[i] + 1;
         end
         if (m_stop) begin m_run = 0; m_burst = 0; end
         else if (m_start) begin m_run = 1; m_burst = 0; end
         else if (m_run && tx_evt[1]) begin
            if (m_burst == BURST - 1) begin m_run = 0; m_burst = 0; end
            else m_burst++;
         end
      end
   end

   function automatic logic [31:0] mread(logic [7:0] a);
      longint unsigned v;
      int idx;
      if (a == 8'h00) return {25'b0, m_snap, 5'b0, m_run};
      if (a >= 8'h20 && a < 8'h50 && a[1:0] == 2'b00) begin
         idx = (int'(a) - 'h20) / 8;
         v = m_snap ? m_shad[idx] : m_live[idx];
         return a[2] ? v[63:32] : v[31:0];
      end
      return 32'h0;
   endfunction

   task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errs++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // per-clock comparison against the model
   always @(negedge clk) begin
      #1;
      if (rst_n) begin
         chk({phase, " gen_enable vs model"}, 64'(gen_enable), 64'(m_run));
         chk({phase, " rdata vs model"}, 64'(reg_rdata), 64'(mread(reg_addr)));
      end
   end

   task automatic cyc(bit wr, logic [7:0] a, logic [31:0] d, logic [2:0] tx, logic [2:0] rx);
      @(negedge clk);
      reg_wr = wr; reg_addr = a; reg_wdata = d; tx_evt = tx; rx_evt = rx;
   endtask

   task automatic rd_chk(string tag, logic [7:0] a, logic [31:0] exp);
      cyc(0, a, 32'h0, 3'b000, 3'b000);
      #2;
      chk(tag, 64'(reg_rdata), 64'(exp));
   endtask

   task automatic packets(int n);
      for (int p = 0; p < n; p++) begin
         cyc(0, 8'h00, 0, 3'b001, 3'b001);
         cyc(0, 8'h00, 0, 3'b010, 3'b010);
      end
   endtask

   task automatic finish_run();
      $display("  Result: errors=%0d of %0d checks", errs, checks);
      $finish;
   endtask

   initial begin
      #(20 * 200000);
      errs++; checks++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      #2;
      chk("R1 gen_enable in reset", 64'(gen_enable), 64'(0));
      rst_n = 1'b1;
      // R1 every word zero after reset
      rd_chk("R1 ctrl after reset", 8'h00, 32'h0);
      for (int k = 0; k < 12; k++)
         rd_chk("R1 counter word after reset", 8'(8'h20 + 4 * k), 32'h0);

      // R2 start, R7 readback
      phase = "R2";
      cyc(1, 8'h00, 32'h1, 3'b000, 3'b000);
      rd_chk("R2 R7 ctrl shows running", 8'h00, 32'h1);

      // R3 burst of 16 packets, R5 counting
      phase = "R3";
      packets(BURST - 1);
      #2 chk("R3 still running after 15", 64'(gen_enable), 64'(1));
      packets(1);
      rd_chk("R3 stopped after 16", 8'h00, 32'h0);

      // R6 map
      phase = "R6";
      rd_chk("R6 tx sop low", 8'h20, 32'd16);
      rd_chk("R6 tx sop high", 8'h24, 32'd0);
      rd_chk("R6 tx eop low", 8'h28, 32'd16);
      rd_chk("R6 tx err low", 8'h30, 32'd0);
      rd_chk("R6 rx sop low", 8'h38, 32'd16);
      rd_chk("R6 rx eop low", 8'h40, 32'd16);

      // R5 single-stream and all-bit strobes
      phase = "R5";
      repeat (3) cyc(0, 8'h00, 0, 3'b100, 3'b000);
      repeat (2) cyc(0, 8'h00, 0, 3'b000, 3'b111);
      rd_chk("R5 tx err", 8'h30, 32'd3);
      rd_chk("R5 rx sop", 8'h38, 32'd18);
      rd_chk("R5 rx eop", 8'h40, 32'd18);
      rd_chk("R5 rx err", 8'h48, 32'd2);
      rd_chk("R5 tx sop unchanged", 8'h20, 32'd16);

      // R8 capture, R9 shadow reads
      phase = "R8";
      cyc(1, 8'h00, 32'h40, 3'b000, 3'b000);
      repeat (5) cyc(0, 8'h00, 0, 3'b001, 3'b000);
      rd_chk("R9 shadow tx sop", 8'h20, 32'd16);
      rd_chk("R7 snapshot bit", 8'h00, 32'h40);
      cyc(1, 8'h00, 32'h40, 3'b000, 3'b000);
      rd_chk("R8 no reload while set", 8'h20, 32'd16);

      // R10 ignored writes, unmapped reads
      phase = "R10";
      cyc(1, 8'h20, 32'hFFFF, 3'b000, 3'b000);
      cyc(1, 8'h04, 32'h1, 3'b000, 3'b000);
      cyc(1, 8'h24, 32'h4, 3'b000, 3'b000);
      rd_chk("R10 counter write ignored", 8'h20, 32'd16);
      rd_chk("R10 foreign write no start", 8'h00, 32'h40);
      rd_chk("R10 unmapped 0x50", 8'h50, 32'h0);
      rd_chk("R10 unaligned 0x22", 8'h22, 32'h0);
      rd_chk("R10 unmapped 0x10", 8'h10, 32'h0);
      rd_chk("R10 unmapped 0xFC", 8'hFC, 32'h0);

      // R9 release shows live values
      phase = "R9";
      cyc(1, 8'h00, 32'h0, 3'b000, 3'b000);
      rd_chk("R9 live after release", 8'h20, 32'd21);
      cyc(1, 8'h00, 32'h40, 3'b000, 3'b000);
      cyc(0, 8'h00, 0, 3'b001, 3'b000);
      rd_chk("R8 fresh capture", 8'h20, 32'd21);

      // R4 stop with simultaneous strobes
      phase = "R4";
      cyc(1, 8'h00, 32'h41, 3'b000, 3'b000);
      cyc(1, 8'h00, 32'h4, 3'b111, 3'b111);
      rd_chk("R4 ctrl after stop", 8'h00, 32'h0);
      for (int k = 0; k < 12; k++)
         rd_chk("R4 counter cleared", 8'(8'h20 + 4 * k), 32'h0);

      // R2 restart mid-run
      phase = "R2";
      cyc(1, 8'h00, 32'h1, 3'b000, 3'b000);
      packets(10);
      cyc(1, 8'h00, 32'h1, 3'b000, 3'b000);
      packets(10);
      #2 chk("R2 restart keeps running", 64'(gen_enable), 64'(1));
      packets(6);
      rd_chk("R2 restarted burst ends", 8'h00, 32'h0);
      rd_chk("R5 tx eop total", 8'h28, 32'd26);

      finish_run();
   end
endmodule